// File: doc/BRIEF.md
# I2C Slave Receiver/Transmitter with Separate Acknowledge Pin

This block is the serial front end of a bus peripheral on a two-wire I2C bus. The data line reaches the block on two pins. `sda_i` samples the level on the wire. `sda_pull_o` controls an external open-drain pull-down that is tied to the same wire. Both bus inputs are oversampled on the system clock. The block detects START and STOP conditions, takes in the address byte and acknowledges it when the address matches the configured one. In write transfers it hands each received byte to the core with a one-cycle strobe. In read transfers it requests bytes from the core and shifts them out.

The acknowledge for received bytes and the read data both leave through `sda_pull_o`. During the acknowledge clock of a byte that the slave transmits, the slave releases the line so the master can answer. When the master answers a byte with a not-acknowledge, the read ends. The block then keeps the line released until the next START or STOP. A START or STOP at any point drops the byte in progress.

Top module: `i2c_split_ack_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `rx_valid_o` and `tx_ready_o` are all 0.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with the line released. In idle, clocked bits are not acknowledged and produce no `rx_valid_o`.
- R3: The first byte after a START is the address byte, sent MSB first. Bits 7..1 are compared with `dev_addr_i` and bit 0 selects the direction (1 = read). On a match, `sda_pull_o` is 1 (line pulled low) through the ninth clock.
- R4: An address mismatch gets no acknowledge. Until the next START, later bytes get no acknowledge and raise no `rx_valid_o`.
- R5: In a write transfer, each data byte is shifted in MSB first. `rx_data_o` presents the byte together with a single-cycle `rx_valid_o` pulse, raised while SCL is still high after the eighth rising edge.
- R6: In a write transfer, every data byte is acknowledged on the ninth clock.
- R7: In a read transfer, a single-cycle `tx_ready_o` pulse is raised after a matching read address and after each master acknowledge. `tx_data_i` is sampled on the SCL falling edge that ends that acknowledge clock. Its bits are then driven MSB first, with `sda_pull_o` equal to the inverse of each bit.
- R8: During the acknowledge clock of a byte the slave transmits, `sda_pull_o` is 0.
- R9: After a master not-acknowledge, `sda_pull_o` stays 0 and no further `tx_ready_o` is raised until the next START or STOP.
- R10: `sda_pull_o` changes only while the synchronized SCL is low.
- R11: A repeated START in the middle of a byte drops that byte without an `rx_valid_o` and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock sample |
| sda_i | input | 1 | Bus data sample |
| dev_addr_i | input | 7 | Configured slave address |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_data_i | input | 8 | Next byte to return to the master |
| tx_ready_o | output | 1 | One-cycle request for tx_data_i |

## Verification
The checker watches four things on every cycle: that the pull-down moves only while the synchronized SCL is low, that both strobes are single-cycle and never coincide, that `rx_valid_o` lands inside the SCL high phase, and that the line is released right after any START or STOP. Several behaviours need whole bus transactions from the bench and cannot be seen cycle by cycle. These are the address filtering, the byte values in both directions, the acknowledge levels seen on the wired line, the silence after a mismatch or a master not-acknowledge, and the dropping of a partial byte by a repeated START.

// File: rtl/i2c_split_pkg.sv
package i2c_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_d;
  assign scl_fall_o = ~scl_s_i & scl_d;
  // data edges only count as conditions while clock held high
  assign start_o    = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d & ~sda_d & sda_s_i;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_split_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_ready_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(DATA_W + 1);

  slv_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, txsh, sh_next;
  logic              match, rd, mack;
  logic              addr_hit;
  logic [IDX_W-1:0]  tx_idx;

  assign sh_next  = {shreg[DATA_W-2:0], sda_i};
  assign addr_hit = (sh_next[DATA_W-1:1] == dev_addr_i);
  assign tx_idx   = IDX_W'(DATA_W - 1) - cnt[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      txsh       <= '0;
      match      <= 1'b0;
      rd         <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_ready_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_ready_o <= 1'b0;
      if (stop_i) begin
        st         <= ST_IDLE;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        st         <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (st == ST_ADDR || st == ST_WRITE || st == ST_READ) begin
        if (scl_rise_i) begin
          if (cnt < ACK_SLOT) begin
            shreg <= sh_next;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (st == ST_ADDR) begin
                match      <= addr_hit;
                rd         <= sda_i;
                tx_ready_o <= addr_hit & sda_i;
              end else if (st == ST_WRITE) begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= sh_next;
              end
            end
          end else if (cnt == ACK_SLOT) begin
            cnt  <= cnt + 1'b1;
            mack <= ~sda_i;
            if (st == ST_READ && !sda_i) tx_ready_o <= 1'b1;
          end
        end else if (scl_fall_i) begin
          if (cnt == ACK_SLOT) begin
            // ack slot opens: slave acks address/write, releases on read
            unique case (st)
              ST_ADDR:  sda_pull_o <= match;
              ST_WRITE: sda_pull_o <= 1'b1;
              default:  sda_pull_o <= 1'b0;
            endcase
          end else if (cnt == ACK_END) begin
            cnt <= '0;
            unique case (st)
              ST_ADDR: begin
                if (!match) begin
                  st         <= ST_SKIP;
                  sda_pull_o <= 1'b0;
                end else if (rd) begin
                  st         <= ST_READ;
                  txsh       <= tx_data_i;
                  sda_pull_o <= ~tx_data_i[DATA_W-1];
                end else begin
                  st         <= ST_WRITE;
                  sda_pull_o <= 1'b0;
                end
              end
              ST_READ: begin
                if (mack) begin
                  txsh       <= tx_data_i;
                  sda_pull_o <= ~tx_data_i[DATA_W-1];
                end else begin
                  st         <= ST_SKIP;
                  sda_pull_o <= 1'b0;
                end
              end
              default: sda_pull_o <= 1'b0;
            endcase
          end else if (st == ST_READ && cnt != '0) begin
            sda_pull_o <= ~txsh[tx_idx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_split_ack_slave.sv
module i2c_split_ack_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_slave_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_s),
    .dev_addr_i(dev_addr_i),
    .tx_data_i (tx_data_i),
    .sda_pull_o(sda_pull_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .tx_ready_o(tx_ready_o)
  );
endmodule

// File: rtl/i2c_split_ack_chk.sv
module i2c_split_ack_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull_o,
  input logic rx_valid_o,
  input logic tx_ready_o
);
  p_pull_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s);

  p_rx_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rx_scl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> scl_s);

  p_tx_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);

  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && tx_ready_o));

  p_stop_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o);

  p_start_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_pull_o);
endmodule

bind i2c_split_ack_slave i2c_split_ack_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull_o(sda_pull_o),
  .rx_valid_o(rx_valid_o),
  .tx_ready_o(tx_ready_o)
);

// File: tb/tb_i2c_split_ack_slave.sv
module tb_i2c_split_ack_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;      // clocks per quarter SCL period
  localparam int WD_CYCLES  = 190000;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic [6:0] dev_addr_i = DEV;
  logic sda_pull_o;
  logic [7:0] rx_data_o;
  logic rx_valid_o;
  logic [7:0] tx_data_i = 8'h00;
  logic tx_ready_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  int tx_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus line
  assign sda_line = m_sda & ~sda_pull_o;

  i2c_split_ack_slave dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .dev_addr_i(dev_addr_i),
    .sda_pull_o(sda_pull_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .tx_data_i (tx_data_i),
    .tx_ready_o(tx_ready_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) rx_q.push_back(rx_data_o);
    if (tx_ready_o) begin
      logic [7:0] b;
      b = 8'($urandom);
      tx_data_i = b;
      tx_q.push_back(b);
      tx_pulses++;
    end
  end

  function automatic logic exp_ack(input logic [6:0] a);
    return (a == DEV) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic clk_bit(input logic drv, output logic line);
    m_sda = drv;  wq(Q);
    scl = 1'b1;   wq(Q);
    line = sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic l;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], l);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic l;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, l);
      b[i] = l;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    logic ack;
    int rx0;
    logic [7:0] sent[$];
    rx0 = rx_q.size();
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(ack == exp_ack(a), (a == DEV) ? "R3 addr ack" : "R4 addr nack", ack, exp_ack(a));
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      sent.push_back(d);
      send_byte(d, ack);
      check(ack == exp_ack(a), (a == DEV) ? "R6 data ack" : "R4 data nack", ack, exp_ack(a));
    end
    bus_stop();
    if (a == DEV) begin
      check(rx_q.size() == rx0 + n, "R5 rx count", rx_q.size() - rx0, n);
      for (int k = 0; k < n && rx0 + k < rx_q.size(); k++)
        check(rx_q[rx0+k] == sent[k], "R5 rx byte", rx_q[rx0+k], sent[k]);
    end else begin
      check(rx_q.size() == rx0, "R4 no rx", rx_q.size() - rx0, 0);
    end
  endtask

  task automatic do_read(input int n);
    logic ack, l;
    logic [7:0] got;
    int t0, p0;
    t0 = tx_q.size();
    p0 = tx_pulses;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R3 read addr ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(got);
      check(t0 + k < tx_q.size(), "R7 tx request", tx_q.size() - t0, k + 1);
      if (t0 + k < tx_q.size())
        check(got == tx_q[t0+k], "R7 tx byte", got, tx_q[t0+k]);
      clk_bit((k == n - 1), l);
      if (k == n - 1) check(l == 1'b1, "R8 release on master ack slot", l, 1);
    end
    recv_byte(got);
    check(got == 8'hFF, "R9 released after nack", got, 8'hFF);
    check(tx_pulses - p0 == n, "R9 no request after nack", tx_pulses - p0, n);
    bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack, l;
    logic [7:0] got;
    int r0, p0;
    void'($urandom(32'd2024));
    wq(5);
    check(sda_pull_o == 1'b0, "R1 pull reset", sda_pull_o, 0);
    check(rx_valid_o == 1'b0, "R1 rx_valid reset", rx_valid_o, 0);
    check(tx_ready_o == 1'b0, "R1 tx_ready reset", tx_ready_o, 0);
    rst_ni = 1'b1;
    wq(5);

    // directed write and read at fixed values
    do_write(DEV, 2);
    do_read(1);

    // address mismatch
    do_write(DEV ^ 7'h01, 2);
    do_write(DEV ^ 7'h40, 1);

    // idle after stop: bits without START are ignored
    r0 = rx_q.size();
    m_sda = 1'b1; scl = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
    send_byte({DEV, 1'b0}, ack);
    check(ack == 1'b1, "R2 idle no ack", ack, 1);
    send_byte(8'h5A, ack);
    check(ack == 1'b1, "R2 idle data no ack", ack, 1);
    check(rx_q.size() == r0, "R2 idle no rx", rx_q.size() - r0, 0);
    bus_stop();

    // repeated START in the middle of a write byte
    r0 = rx_q.size();
    p0 = tx_pulses;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack == 1'b0, "R11 addr ack", ack, 0);
    clk_bit(1'b1, l); clk_bit(1'b0, l); clk_bit(1'b1, l); clk_bit(1'b1, l);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R11 restart addr ack", ack, 0);
    recv_byte(got);
    check(tx_pulses - p0 == 1, "R11 tx request", tx_pulses - p0, 1);
    if (tx_q.size() > 0)
      check(got == tx_q[tx_q.size()-1], "R11 read after restart", got, tx_q[tx_q.size()-1]);
    clk_bit(1'b1, l);
    bus_stop();
    check(rx_q.size() == r0, "R11 partial byte dropped", rx_q.size() - r0, 0);

    // randomized transfers
    for (int t = 0; t < 8; t++) begin
      int n;
      n = 1 + int'($urandom_range(3));
      if ($urandom_range(1) == 0) do_write(DEV, n);
      else                        do_read(n);
    end
    do_write(7'($urandom) | 7'h01 ^ ((DEV & 7'h01) == 0 ? 7'h00 : 7'h01) ^ 7'h00, 1);

    check(sda_pull_o == 1'b0, "R2 released at end", sda_pull_o, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule